// File: doc/BRIEF.md
# Serial Clock Divisor and Receive Timing Selector

This block turns a reference clock frequency and a wanted serial clock frequency, both given as plain integers in hertz, into the settings a serial flash controller needs. It returns a 3-bit power-of-two divisor code, the serial clock frequency that code gives, and a set of receive capture controls: a tap-delay bypass flag, a loopback enable, a loopback delay code, and a data-delay enable with its delay value.

A request is started with a one-cycle `start`. The block samples both frequencies and clamps the request to the reference. It then walks the divisor code upward, one code per clock cycle, until the divided clock no longer exceeds the request. It rounds out the result and raises `done` for one cycle, with all outputs updated on that same edge. If the clamped request equals the frequency already reported, the block skips the search. It answers with `done` on the next cycle and leaves every output as it was.

Top module: `spi_clkdiv_sel`

## Requirements
- R1: After reset `busy` and `done` are 0 and `div_code`, `act_hz` and all five receive timing outputs are 0.
- R2: A request above the reference is treated as equal to the reference, which gives code 0.
- R3: The code is the smallest value c from 0 to 7 for which the reference shifted right by c+1 is not greater than the clamped request.
- R4: When no code from 0 to 7 satisfies R3, the code becomes 2.
- R5: `act_hz` equals the sampled reference shifted right by `div_code`+1.
- R6: When `act_hz` is below 40,000,000, only `tap_bypass` is 1. `lpbk_en`, `ddly_en`, `lpbk_dly` and `ddly_val` are 0.
- R7: When `act_hz` is from 40,000,000 to 100,000,000 inclusive, `tap_bypass`, `lpbk_en` and `ddly_en` are 1, `ddly_val` is 2 and `lpbk_dly` is 0.
- R8: When `act_hz` is above 100,000,000 and at most 150,000,000, `lpbk_en` is 1 and `lpbk_dly` is 3. `tap_bypass`, `ddly_en` and `ddly_val` are 0.
- R9: When `act_hz` is above 150,000,000, all five receive timing outputs are 0.
- R10: When the clamped request equals the current `act_hz`, `done` rises on the edge after the start, `busy` stays 0, and no output changes.
- R11: Each accepted start yields exactly one one-cycle `done` pulse. A start is accepted only while `busy` and `done` are both 0. A start raised while `busy` is 1 or `done` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new computation |
| ref_hz | input | 32 | Reference clock frequency in Hz |
| req_hz | input | 32 | Wanted serial clock frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| div_code | output | 3 | Divisor code; divider is 2 << code |
| act_hz | output | 32 | Resulting serial clock frequency in Hz |
| tap_bypass | output | 1 | Receive tap-delay bypass |
| lpbk_en | output | 1 | Loopback capture enable |
| lpbk_dly | output | 2 | Loopback delay code |
| ddly_en | output | 1 | Data-delay enable |
| ddly_val | output | 2 | Data-delay value |

## Verification
Two events can land on the same edge: the `done` pulse that ends one request and a `start` for the next request. The bench raises `start` with a different request exactly in the `done` cycle. It then expects no further `done` pulse, `busy` to stay 0, and the outputs to keep the first result. A second `start`, raised during a search, must likewise leave the result of the first request in place. Only one `done` pulse may follow.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

    localparam int DLY_W = 2;
    localparam logic [DLY_W-1:0] DDLY_MID = 2'd2;
    localparam logic [DLY_W-1:0] LPBK_HI  = 2'd3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } fsm_t;

    typedef struct packed {
        logic             tap_bypass;
        logic             lpbk_en;
        logic [DLY_W-1:0] lpbk_dly;
        logic             ddly_en;
        logic [DLY_W-1:0] ddly_val;
    } rx_timing_t;

    // Priority chain: low band, then middle band, then high band, else none.
    function automatic rx_timing_t timing_for(input logic below_lo,
                                              input logic le_mid,
                                              input logic le_hi);
        rx_timing_t t;
        t = '0;
        if (below_lo) begin
            t.tap_bypass = 1'b1;
        end else if (le_mid) begin
            t.tap_bypass = 1'b1;
            t.lpbk_en    = 1'b1;
            t.ddly_en    = 1'b1;
            t.ddly_val   = DDLY_MID;
        end else if (le_hi) begin
            t.lpbk_en    = 1'b1;
            t.lpbk_dly   = LPBK_HI;
        end
        return t;
    endfunction

endpackage

// File: rtl/spi_div_search.sv
module spi_div_search #(
    parameter int FREQ_W = 32,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [FREQ_W-1:0] ref_in,
    input  logic [FREQ_W-1:0] req_in,
    output logic [CODE_W:0]   cnt,
    output logic [FREQ_W-1:0] ref_q,
    output logic              stop
);
    localparam int CNT_W = CODE_W + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 ** CODE_W);

    logic [FREQ_W-1:0] req_q;
    logic [CNT_W:0]    sh;
    logic [FREQ_W-1:0] divided;

    always_comb begin
        sh      = {1'b0, cnt} + (CNT_W + 1)'(1);
        divided = ref_q >> sh;
        stop    = (cnt == LIMIT) || (divided <= req_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ref_q <= '0;
            req_q <= '0;
        end else if (load) begin
            cnt   <= '0;
            ref_q <= ref_in;
            req_q <= req_in;
        end else if (step && !stop) begin
            cnt   <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_div_band.sv
module spi_div_band
    import spi_div_pkg::*;
#(
    parameter int          FREQ_W   = 32,
    parameter int unsigned BAND_LO  = 40_000_000,
    parameter int unsigned BAND_MID = 100_000_000,
    parameter int unsigned BAND_HI  = 150_000_000
) (
    input  logic [FREQ_W-1:0] freq,
    output rx_timing_t        timing
);
    localparam logic [FREQ_W-1:0] LO_V  = FREQ_W'(BAND_LO);
    localparam logic [FREQ_W-1:0] MID_V = FREQ_W'(BAND_MID);
    localparam logic [FREQ_W-1:0] HI_V  = FREQ_W'(BAND_HI);

    always_comb begin
        timing = timing_for(freq < LO_V, freq <= MID_V, freq <= HI_V);
    end
endmodule

// File: rtl/spi_clkdiv_sel.sv
module spi_clkdiv_sel
    import spi_div_pkg::*;
#(
    parameter int          FREQ_W    = 32,
    parameter int          CODE_W    = 3,
    parameter int          DFLT_CODE = 2,
    parameter int unsigned BAND_LO   = 40_000_000,
    parameter int unsigned BAND_MID  = 100_000_000,
    parameter int unsigned BAND_HI   = 150_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_hz,
    input  logic [FREQ_W-1:0] req_hz,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] div_code,
    output logic [FREQ_W-1:0] act_hz,
    output logic              tap_bypass,
    output logic              lpbk_en,
    output logic [DLY_W-1:0]  lpbk_dly,
    output logic              ddly_en,
    output logic [DLY_W-1:0]  ddly_val
);
    localparam int CNT_W = CODE_W + 1;
    localparam logic [CNT_W-1:0]  MAX_CODE = CNT_W'(2 ** CODE_W - 1);
    localparam logic [CODE_W-1:0] DFLT_V   = CODE_W'(DFLT_CODE);

    fsm_t              state;
    logic [FREQ_W-1:0] req_clamp;
    logic              accept, skip, load, stop;
    logic [CNT_W-1:0]  cnt;
    logic [FREQ_W-1:0] ref_q;
    logic [CODE_W-1:0] fin_code;
    logic [CODE_W:0]   fin_sh;
    logic [FREQ_W-1:0] fin_act;
    rx_timing_t        fin_tm, tm_q;

    always_comb begin
        req_clamp = (req_hz > ref_hz) ? ref_hz : req_hz;
        accept    = start && (state == ST_IDLE) && !done;
        skip      = (req_clamp == act_hz);
        load      = accept && !skip;
        fin_code  = (cnt > MAX_CODE) ? DFLT_V : cnt[CODE_W-1:0];
        fin_sh    = {1'b0, fin_code} + (CODE_W + 1)'(1);
        fin_act   = ref_q >> fin_sh;
    end

    spi_div_search #(.FREQ_W(FREQ_W), .CODE_W(CODE_W)) u_search (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (state == ST_SEARCH),
        .ref_in (ref_hz),
        .req_in (req_clamp),
        .cnt    (cnt),
        .ref_q  (ref_q),
        .stop   (stop)
    );

    spi_div_band #(
        .FREQ_W(FREQ_W), .BAND_LO(BAND_LO), .BAND_MID(BAND_MID), .BAND_HI(BAND_HI)
    ) u_band (
        .freq   (fin_act),
        .timing (fin_tm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            div_code <= '0;
            act_hz   <= '0;
            tm_q     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (skip) done  <= 1'b1;
                        else      state <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (stop) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        div_code <= fin_code;
                        act_hz   <= fin_act;
                        tm_q     <= fin_tm;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_SEARCH);
    assign tap_bypass = tm_q.tap_bypass;
    assign lpbk_en    = tm_q.lpbk_en;
    assign lpbk_dly   = tm_q.lpbk_dly;
    assign ddly_en    = tm_q.ddly_en;
    assign ddly_val   = tm_q.ddly_val;
endmodule

// File: rtl/spi_clkdiv_sel_chk.sv
module spi_clkdiv_sel_chk #(
    parameter int          FREQ_W   = 32,
    parameter int          CODE_W   = 3,
    parameter int          DLY_W    = 2,
    parameter int unsigned BAND_LO  = 40_000_000,
    parameter int unsigned BAND_MID = 100_000_000,
    parameter int unsigned BAND_HI  = 150_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] div_code,
    input logic [FREQ_W-1:0] act_hz,
    input logic              tap_bypass,
    input logic              lpbk_en,
    input logic [DLY_W-1:0]  lpbk_dly,
    input logic              ddly_en,
    input logic [DLY_W-1:0]  ddly_val
);
    localparam logic [FREQ_W-1:0] LO_V  = FREQ_W'(BAND_LO);
    localparam logic [FREQ_W-1:0] MID_V = FREQ_W'(BAND_MID);
    localparam logic [FREQ_W-1:0] HI_V  = FREQ_W'(BAND_HI);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R11
    AST_HOLD_OUTSIDE_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(div_code) && $stable(act_hz) && $stable(lpbk_en))); // R10
    AST_BAND_LOW: assert property (@(posedge clk) disable iff (rst)
        (done && act_hz < LO_V) |->
        (tap_bypass && !lpbk_en && !ddly_en && lpbk_dly == '0 && ddly_val == '0)); // R6
    AST_BAND_MID: assert property (@(posedge clk) disable iff (rst)
        (done && act_hz >= LO_V && act_hz <= MID_V) |->
        (tap_bypass && lpbk_en && ddly_en && ddly_val == DLY_W'(2) && lpbk_dly == '0)); // R7
    AST_BAND_HIGH: assert property (@(posedge clk) disable iff (rst)
        (done && act_hz > MID_V && act_hz <= HI_V) |->
        (!tap_bypass && lpbk_en && !ddly_en && lpbk_dly == DLY_W'(3) && ddly_val == '0)); // R8
    AST_BAND_NONE: assert property (@(posedge clk) disable iff (rst)
        (done && act_hz > HI_V) |->
        (!tap_bypass && !lpbk_en && !ddly_en && lpbk_dly == '0 && ddly_val == '0)); // R9
endmodule

bind spi_clkdiv_sel spi_clkdiv_sel_chk #(
    .FREQ_W(FREQ_W), .CODE_W(CODE_W), .DLY_W(spi_div_pkg::DLY_W),
    .BAND_LO(BAND_LO), .BAND_MID(BAND_MID), .BAND_HI(BAND_HI)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .div_code(div_code), .act_hz(act_hz), .tap_bypass(tap_bypass),
    .lpbk_en(lpbk_en), .lpbk_dly(lpbk_dly), .ddly_en(ddly_en), .ddly_val(ddly_val)
);

// File: tb/tb_spi_clkdiv_sel.sv
module tb_spi_clkdiv_sel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] req_hz = '0;
    logic        busy, done, tap_bypass, lpbk_en, ddly_en;
    logic [2:0]  div_code;
    logic [31:0] act_hz;
    logic [1:0]  lpbk_dly, ddly_val;

    int n_chk = 0;
    int n_err = 0;

    // model state: last reported result
    logic [2:0]  m_code = '0;
    logic [31:0] m_act  = '0;
    logic [6:0]  m_tm   = '0;

    always #10 clk = ~clk;

    spi_clkdiv_sel dut (
        .clk(clk), .rst(rst), .start(start), .ref_hz(ref_hz), .req_hz(req_hz),
        .busy(busy), .done(done), .div_code(div_code), .act_hz(act_hz),
        .tap_bypass(tap_bypass), .lpbk_en(lpbk_en), .lpbk_dly(lpbk_dly),
        .ddly_en(ddly_en), .ddly_val(ddly_val)
    );

    function automatic logic [6:0] tm_now();
        return {tap_bypass, lpbk_en, lpbk_dly, ddly_en, ddly_val};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint unsigned a,
                       input longint unsigned e);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
        end
    endtask

    function automatic logic [31:0] clampf(input logic [31:0] r, input logic [31:0] q);
        return (q > r) ? r : q;
    endfunction

    task automatic model(input logic [31:0] r, input logic [31:0] q,
                         output logic [2:0] c_o, output logic [31:0] a_o,
                         output logic [6:0] t_o);
        logic [31:0] cq;
        int c;
        cq = clampf(r, q);
        c = 0;
        while (c < 8 && (r >> (c + 1)) > cq) c++;
        if (c > 7) c = 2;
        c_o = 3'(c);
        a_o = r >> (c + 1);
        if (a_o < 32'd40_000_000)       t_o = 7'b1_0_00_0_00;
        else if (a_o <= 32'd100_000_000) t_o = 7'b1_1_00_1_10;
        else if (a_o <= 32'd150_000_000) t_o = 7'b0_1_11_0_00;
        else                             t_o = 7'b0_0_00_0_00;
    endtask

    task automatic check_result(input string tag);
        chk(div_code == m_code, {tag, " R3 R4 code"}, div_code, m_code);
        chk(act_hz == m_act, {tag, " R5 act"}, act_hz, m_act);
        chk(tm_now() == m_tm, {tag, " R6 R7 R8 R9 timing"}, tm_now(), m_tm);
    endtask

    task automatic run_op(input logic [31:0] r, input logic [31:0] q);
        bit sk;
        sk = (clampf(r, q) == m_act);
        @(negedge clk);
        ref_hz = r; req_hz = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (sk) begin
            chk(done && !busy, "R10 skip done", {done, busy}, 2'b10);
            check_result("R10 unchanged");
        end else begin
            chk(busy, "R11 busy after start", busy, 1);
            for (int i = 0; i < 20 && !done; i++) @(negedge clk);
            chk(done, "R11 done seen", done, 1);
            model(r, q, m_code, m_act, m_tm);
            if (q > r) chk(div_code == 3'd0, "R2 clamp code", div_code, 0);
            check_result("sweep");
        end
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] refs [9];
        int pulses;
        refs = '{32'd200_000_000, 32'd300_000_000, 32'd300_000_002, 32'd200_000_002,
                 32'd80_000_000, 32'd79_999_998, 32'd1000, 32'd0, 32'hFFFF_FFFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 handshake idle", {busy, done}, 0);
        chk(div_code == 0 && act_hz == 0 && tm_now() == 0, "R1 outputs zero",
            act_hz, 0);

        // R4 fallback, with a start during the search (R11)
        ref_hz = 32'd300_000_000; req_hz = 32'd1; start = 1'b1;
        @(negedge clk);
        req_hz = 32'd300_000_000;          // still high: arrives while busy
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        model(32'd300_000_000, 32'd1, m_code, m_act, m_tm);
        chk(done, "R11 done first request", done, 1);
        chk(div_code == 3'd2, "R4 fallback code", div_code, 2);
        check_result("R11 busy start ignored");
        // start in the done cycle must be ignored (R11)
        ref_hz = 32'd200_000_000; req_hz = 32'd200_000_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int i = 0; i < 15; i++) begin
            if (done || busy) pulses++;
            @(negedge clk);
        end
        chk(pulses == 0, "R11 start in done cycle ignored", pulses, 0);
        check_result("R11 after done-cycle start");

        // sweep
        foreach (refs[j]) begin
            run_op(refs[j], 32'd0);
            run_op(refs[j], 32'hFFFF_FFFF);
            for (int k = 0; k <= 10; k++) begin
                run_op(refs[j], refs[j] >> k);
                run_op(refs[j], (refs[j] >> k) + 32'd1);
                run_op(refs[j], (refs[j] >> k) - 32'd1);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule